// File: doc/BRIEF.md
# Framed SPI Command Slave with Silent Timeouts

This block is the slave end of a command/response SPI link for a small peripheral. The host master shifts in a one-byte opcode. Depending on the opcode, argument bytes follow. When the last argument byte has arrived, the block sends a one-cycle command strobe carrying the opcode and its arguments toward a register file. If the opcode has a response, the block captures the response word and raises its data-ready output. The host then clocks the response out by sending placeholder bytes. A per-opcode parameter table sets the number of argument bytes and the number of response bytes.

A null opcode (0x00) does nothing; its only use is as the placeholder byte that lets the host clock data back. Any byte the host sends while an intermediate response byte is shifting out is discarded. The byte the host sends during the final response byte is taken as a fresh opcode, so commands can be chained back to back. Two silent watchdogs guard every transaction. One limits the gap between successive bytes. The other limits the whole exchange for commands that return two or more bytes. When either one expires, the command is dropped with no flag and the block waits for a new opcode. Both watchdogs count ticks from a parameterised prescaler.

The serial pins are sampled through a small synchronizer into the system clock domain. SPI mode 0 is used, with the most significant bit first. Raising chip select clears a partly received byte but leaves the command in progress untouched.

Top module: `cmdlink_slave`

## Requirements
- R1: While reset is held and in the cycles right after it, drdy and cmd_valid are 0, and miso reads 0 for any byte clocked out.
- R2: Bytes are received MSB first on SCK rising edges (mode 0). With the default table, opcodes 1, 2 and 3 take no arguments and return 1, 2 and 3 bytes. Opcode 4 takes 1 argument and opcode 5 takes 2, and neither returns anything. Opcode 6 takes 1 argument and returns 2 bytes. Opcode 7 takes 3 arguments and returns nothing. After the last argument byte (or after the opcode, if there are no arguments), cmd_valid pulses for exactly one cycle. During that pulse cmd_op holds the opcode and cmd_args holds the arguments, with the first argument byte in bits 7:0 and the second in bits 15:8.
- R3: In idle, the byte 0x00 and any byte of value NUM_OPS (default 8) or above produce no strobe and leave drdy at 0.
- R4: For a command with a response, rsp_value is sampled during the cmd_valid cycle, and drdy rises in the following cycle. The response bytes are then sent least significant byte first. drdy returns to 0 once the last response byte has been received, and stays 0 for commands without a response.
- R5: A byte the host sends during any response byte except the last is ignored, even if it is a valid opcode: no strobe follows, and the later response bytes are unchanged.
- R6: A valid opcode sent during the final response byte starts a new command exactly as it would in idle.
- R7: If more than BYTE_TO prescaler ticks pass between two completed bytes of an unfinished command, the command is dropped silently: no strobe for it ever appears, and the next byte is decoded as an opcode.
- R8: For a command returning two or more bytes, once XACT_TO ticks have passed since its opcode was accepted, the command is dropped. drdy falls and the remaining response bytes read as 0x00.
- R9: Raising cs_n in the middle of a byte discards that byte's bits without aborting the current command. The next full byte is framed from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the host (asynchronous) |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the host |
| drdy | output | 1 | High while response bytes are staged for the host |
| cmd_valid | output | 1 | One-cycle strobe for a fully received command |
| cmd_op | output | 8 | Opcode of the strobed command |
| cmd_args | output | 24 | Argument bytes, first byte in bits 7:0 |
| rsp_value | input | 24 | Response word from the register file, sampled during cmd_valid |

## Verification
The completion of the final response byte and the decoding of a new opcode happen in one and the same cycle. The bench provokes this by sending a valid opcode in place of the last placeholder. It then confirms that the new command's strobe and its response appear. A contrasting case sends valid opcodes during intermediate response bytes and confirms that they are ignored. The two watchdogs are separated by timing: the whole-exchange test keeps each byte gap below the inter-byte limit, so a drop of drdy can only come from the total window. The inter-byte test then shows that the byte arriving after an expired gap is taken as a new opcode.

// File: rtl/cmdlink_pkg.sv
`timescale 1ns/1ps
package cmdlink_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 3;
    localparam int WORD_W    = BYTE_W * MAX_BYTES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        cnt2_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARGS  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_RESP  = 2'd3
    } cl_state_e;

    // Byte counts of one opcode, taken from the parameter tables.
    typedef struct packed {
        cnt2_t n_args;
        cnt2_t n_rsp;
    } op_shape_t;

    // A byte opens a command only when it is neither null nor beyond the table.
    function automatic logic opens_command(input byte_t b, input int unsigned num_ops);
        return (b != '0) && (int'(b) < int'(num_ops));
    endfunction

endpackage

// File: rtl/cmdlink_sync.sv
`timescale 1ns/1ps
module cmdlink_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmdlink_shift.sv
`timescale 1ns/1ps
module cmdlink_shift
    import cmdlink_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sck_s,
    input  logic  mosi_s,
    input  logic  cs_n_s,
    input  logic  tx_load,
    input  byte_t tx_byte,
    input  logic  tx_clear,
    output logic  rx_valid,
    output byte_t rx_byte,
    output logic  miso
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic             sck_d;
    logic             rise, fall;
    logic [BIT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] rx_sr;
    byte_t            tx_sr;

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    // Receive side: bit counter framed by chip select.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(BYTE_W-1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr, mosi_s};
                end
            end
        end
    end

    // Transmit side: shift on falling edges inside a byte only, so the edge
    // that follows the last sampling edge keeps a freshly loaded byte intact.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (tx_clear) begin
            tx_sr <= '0;
        end else if (tx_load) begin
            tx_sr <= tx_byte;
        end else if (fall && !cs_n_s && bit_cnt != '0) begin
            tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = ~cs_n_s & tx_sr[BYTE_W-1];
endmodule

// File: rtl/cmdlink_timer.sv
`timescale 1ns/1ps
module cmdlink_timer #(
    parameter int TICK_DIV = 1000,
    parameter int BYTE_TO  = 110,
    parameter int XACT_TO  = 110
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic byte_seen,
    input  logic xact_en,
    output logic gap_expired,
    output logic xact_expired
);
    localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int GAP_W  = $clog2(BYTE_TO + 1);
    localparam int XACT_W = $clog2(XACT_TO + 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic              tick;
    logic [GAP_W-1:0]  gap_cnt;
    logic [XACT_W-1:0] xact_cnt;

    generate
        if (TICK_DIV > 1) begin : g_presc
            always_ff @(posedge clk) begin
                if (rst || pre_cnt == PRE_W'(TICK_DIV-1)) pre_cnt <= '0;
                else                                      pre_cnt <= pre_cnt + 1'b1;
            end
            assign tick = (pre_cnt == PRE_W'(TICK_DIV-1));
        end else begin : g_nopresc
            always_ff @(posedge clk) pre_cnt <= '0;
            assign tick = 1'b1;
        end
    endgenerate

    // Gap window restarts on every completed byte.
    always_ff @(posedge clk) begin
        if (rst || !run || byte_seen)
            gap_cnt <= '0;
        else if (tick && gap_cnt != GAP_W'(BYTE_TO))
            gap_cnt <= gap_cnt + 1'b1;
    end

    // Whole-exchange window restarts only when an opcode is accepted.
    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            xact_cnt <= '0;
        else if (tick && xact_cnt != XACT_W'(XACT_TO))
            xact_cnt <= xact_cnt + 1'b1;
    end

    assign gap_expired  = run && !byte_seen && (gap_cnt == GAP_W'(BYTE_TO));
    assign xact_expired = run && xact_en && (xact_cnt == XACT_W'(XACT_TO));
endmodule

// File: rtl/cmdlink_slave.sv
`timescale 1ns/1ps
module cmdlink_slave
    import cmdlink_pkg::*;
#(
    parameter int                    NUM_OPS     = 8,
    parameter logic [2*NUM_OPS-1:0]  ARG_TABLE   = 16'hD900,
    parameter logic [2*NUM_OPS-1:0]  RSP_TABLE   = 16'h20E4,
    parameter int                    TICK_DIV    = 1000,
    parameter int                    BYTE_TO     = 110,
    parameter int                    XACT_TO     = 110,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        mosi,
    input  logic        cs_n,
    output logic        miso,
    output logic        drdy,
    output logic        cmd_valid,
    output logic [7:0]  cmd_op,
    output logic [23:0] cmd_args,
    input  logic [23:0] rsp_value
);
    localparam int IDX_W = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1;

    // Per-opcode shape table unpacked from the parameters.
    op_shape_t shape_of [NUM_OPS];
    generate
        for (genvar g = 0; g < NUM_OPS; g++) begin : g_shape
            assign shape_of[g].n_args = ARG_TABLE[2*g +: 2];
            assign shape_of[g].n_rsp  = RSP_TABLE[2*g +: 2];
        end
    endgenerate

    logic sck_s, mosi_s, cs_n_s;
    logic rx_valid;
    byte_t rx_byte;
    logic tx_load, tx_clear;
    byte_t tx_byte;
    logic gap_expired, xact_expired;
    logic restart;

    cmdlink_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_data (
        .clk (clk), .rst (rst), .d ({sck, mosi}), .q ({sck_s, mosi_s})
    );
    cmdlink_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk (clk), .rst (rst), .d (cs_n), .q (cs_n_s)
    );

    cmdlink_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .cs_n_s   (cs_n_s),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .tx_clear (tx_clear),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .miso     (miso)
    );

    cl_state_e st_q, st_n;
    byte_t     op_q, op_n;
    word_t     args_q, args_n;
    word_t     buf_q, buf_n;
    cnt2_t     need_q, need_n, got_q, got_n;
    cnt2_t     rlen_q, rlen_n, ridx_q, ridx_n;
    logic      multi_q, multi_n;
    logic      open_op;
    op_shape_t shp;

    cmdlink_timer #(.TICK_DIV(TICK_DIV), .BYTE_TO(BYTE_TO), .XACT_TO(XACT_TO)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .run          (st_q != ST_IDLE),
        .restart      (restart),
        .byte_seen    (rx_valid),
        .xact_en      (multi_q),
        .gap_expired  (gap_expired),
        .xact_expired (xact_expired)
    );

    assign shp = shape_of[rx_byte[IDX_W-1:0]];

    always_comb begin
        st_n     = st_q;
        op_n     = op_q;
        args_n   = args_q;
        buf_n    = buf_q;
        need_n   = need_q;
        got_n    = got_q;
        rlen_n   = rlen_q;
        ridx_n   = ridx_q;
        multi_n  = multi_q;
        tx_load  = 1'b0;
        tx_clear = 1'b0;
        tx_byte  = '0;
        open_op  = 1'b0;
        restart  = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                open_op = rx_valid;
            end
            ST_ARGS: begin
                // A completed byte beats an expiry in the same cycle.
                if (rx_valid) begin
                    args_n[{got_q, 3'b000} +: BYTE_W] = rx_byte;
                    got_n = got_q + 1'b1;
                    if (got_q + 1'b1 == need_q) st_n = ST_ISSUE;
                end else if (gap_expired || xact_expired) begin
                    st_n = ST_IDLE;
                end
            end
            ST_ISSUE: begin
                if (rlen_q != '0) begin
                    tx_load = 1'b1;
                    tx_byte = rsp_value[BYTE_W-1:0];
                    buf_n   = rsp_value >> BYTE_W;
                    ridx_n  = '0;
                    st_n    = ST_RESP;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_RESP: begin
                if (rx_valid) begin
                    if (ridx_q + 1'b1 == rlen_q) begin
                        tx_clear = 1'b1;
                        st_n     = ST_IDLE;
                        open_op  = 1'b1;
                    end else begin
                        ridx_n  = ridx_q + 1'b1;
                        tx_load = 1'b1;
                        tx_byte = buf_q[BYTE_W-1:0];
                        buf_n   = buf_q >> BYTE_W;
                    end
                end else if (gap_expired || xact_expired) begin
                    tx_clear = 1'b1;
                    st_n     = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        if (open_op && opens_command(rx_byte, NUM_OPS)) begin
            restart = 1'b1;
            op_n    = rx_byte;
            args_n  = '0;
            got_n   = '0;
            need_n  = shp.n_args;
            rlen_n  = shp.n_rsp;
            multi_n = (shp.n_rsp >= 2'd2);
            st_n    = (shp.n_args == '0) ? ST_ISSUE : ST_ARGS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= '0;
            args_q  <= '0;
            buf_q   <= '0;
            need_q  <= '0;
            got_q   <= '0;
            rlen_q  <= '0;
            ridx_q  <= '0;
            multi_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            op_q    <= op_n;
            args_q  <= args_n;
            buf_q   <= buf_n;
            need_q  <= need_n;
            got_q   <= got_n;
            rlen_q  <= rlen_n;
            ridx_q  <= ridx_n;
            multi_q <= multi_n;
        end
    end

    assign cmd_valid = (st_q == ST_ISSUE);
    assign cmd_op    = op_q;
    assign cmd_args  = args_q;
    assign drdy      = (st_q == ST_RESP);
endmodule

// File: rtl/cmdlink_slave_chk.sv
`timescale 1ns/1ps
module cmdlink_slave_chk #(
    parameter int NUM_OPS = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       drdy,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       rx_valid,
    input logic       gap_expired,
    input logic       xact_expired
);
    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R2
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(rx_valid));

    // R3
    strobe_opcode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != 8'h00 && int'(cmd_op) < NUM_OPS));

    // R4
    drdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy) |-> $past(cmd_valid));

    // R8
    drdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drdy) |-> $past(rx_valid || gap_expired || xact_expired));
endmodule

bind cmdlink_slave cmdlink_slave_chk #(.NUM_OPS(NUM_OPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .drdy         (drdy),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .rx_valid     (rx_valid),
    .gap_expired  (gap_expired),
    .xact_expired (xact_expired)
);

// File: tb/cmdlink_slave_tb.sv
`timescale 1ns/1ps
module cmdlink_slave_tb;
    localparam int HALF = 6;
    localparam int TDIV = 4;
    localparam int BTO  = 80;
    localparam int XTO  = 150;

    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso, drdy, cmd_valid;
    logic [7:0]  cmd_op;
    logic [23:0] cmd_args, rsp_value;

    int checks = 0, errors = 0, strobes = 0;
    logic [7:0]  mon_op = '0;
    logic [23:0] mon_args = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [23:0] rsp_model(input logic [7:0] op, input logic [23:0] a);
        return {a[23:16] ^ op, a[15:8] + 8'h11, a[7:0] ^ 8'h5A ^ op};
    endfunction

    function automatic int nargs(input logic [7:0] op);
        case (op)
            8'd4, 8'd6: return 1;
            8'd5:       return 2;
            8'd7:       return 3;
            default:    return 0;
        endcase
    endfunction

    function automatic int nrsp(input logic [7:0] op);
        case (op)
            8'd1:       return 1;
            8'd2, 8'd6: return 2;
            8'd3:       return 3;
            default:    return 0;
        endcase
    endfunction

    assign rsp_value = rsp_model(cmd_op, cmd_args);

    cmdlink_slave #(.TICK_DIV(TDIV), .BYTE_TO(BTO), .XACT_TO(XTO)) u_dut (
        .clk (clk), .rst (rst), .sck (sck), .mosi (mosi), .cs_n (cs_n),
        .miso (miso), .drdy (drdy), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_args (cmd_args), .rsp_value (rsp_value)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            strobes  <= strobes + 1;
            mon_op   <= cmd_op;
            mon_args <= cmd_args;
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            idle(HALF);
            rx[i] = miso;
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic spi_partial(input int nbits);
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = i[0];
            idle(HALF);
            sck = 1'b1;
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic wait_drdy();
        for (int i = 0; i < 40; i++) begin
            if (drdy) break;
            @(negedge clk);
        end
    endtask

    // Full command with response readout; junk selects valid opcodes as fillers
    task automatic run_cmd(input logic [7:0] op, input logic [23:0] args,
                           input bit junk, input logic [7:0] last_tx);
        int s0;
        logic [7:0] rx;
        logic [23:0] a, e;
        s0 = strobes;
        a = args & ((24'h1 << (8 * nargs(op))) - 24'h1);
        spi_byte(op, rx);
        for (int k = 0; k < nargs(op); k++) spi_byte(a[8*k +: 8], rx);
        idle(4);
        check_eq("R2 strobe count", strobes, s0 + 1);
        check_eq("R2 opcode", {24'h0, mon_op}, {24'h0, op});
        check_eq("R2 args order", {8'h0, mon_args}, {8'h0, a});
        e = rsp_model(op, a);
        if (nrsp(op) == 0) begin
            check_eq("R4 drdy low without response", {31'h0, drdy}, 32'h0);
        end else begin
            wait_drdy();
            check_eq("R4 drdy high", {31'h0, drdy}, 32'h1);
            for (int k = 0; k < nrsp(op); k++) begin
                logic [7:0] t;
                if (k == nrsp(op) - 1) t = last_tx;
                else if (junk) t = 8'(1 + ($urandom % 7));
                else t = 8'h00;
                spi_byte(t, rx);
                check_eq("R4 response byte LSB first", {24'h0, rx}, {24'h0, e[8*k +: 8]});
                if (k < nrsp(op) - 1)
                    check_eq("R5 intermediate byte ignored", strobes, s0 + 1);
            end
            if (last_tx == 8'h00) begin
                idle(4);
                check_eq("R4 drdy low after last byte", {31'h0, drdy}, 32'h0);
            end
        end
    endtask

    initial begin
        logic [7:0] rx;
        int s0;
        void'($urandom(32'd20240611));
        idle(10);
        check_eq("R1 drdy in reset", {31'h0, drdy}, 32'h0);
        check_eq("R1 strobe in reset", {31'h0, cmd_valid}, 32'h0);
        rst = 1'b0;
        idle(5);
        check_eq("R1 drdy after reset", {31'h0, drdy}, 32'h0);
        spi_byte(8'h00, rx);
        check_eq("R1 miso idle", {24'h0, rx}, 32'h0);

        // R3: null and out-of-table bytes in idle
        s0 = strobes;
        spi_byte(8'hC3, rx);
        spi_byte(8'h08, rx);
        spi_byte(8'h00, rx);
        idle(4);
        check_eq("R3 no strobe", strobes, s0);
        check_eq("R3 drdy low", {31'h0, drdy}, 32'h0);

        // R2 directed: three-argument opcode and argument order
        run_cmd(8'd7, 24'hC0FFEE, 1'b0, 8'h00);
        run_cmd(8'd3, 24'h0, 1'b0, 8'h00);

        // R5: valid opcodes sent as fillers are ignored
        run_cmd(8'd6, 24'h0000A7, 1'b1, 8'h00);

        // R6: opcode in the final response byte chains a new command
        run_cmd(8'd1, 24'h0, 1'b0, 8'h02);
        idle(4);
        check_eq("R6 chained opcode", {24'h0, mon_op}, 32'h2);
        wait_drdy();
        check_eq("R6 chained drdy", {31'h0, drdy}, 32'h1);
        spi_byte(8'h00, rx);
        check_eq("R6 chained byte0", {24'h0, rx}, {24'h0, rsp_model(8'd2, 24'h0) & 24'hFF});
        spi_byte(8'h00, rx);
        check_eq("R6 chained byte1", {24'h0, rx}, {24'h0, 8'(rsp_model(8'd2, 24'h0) >> 8)});

        // R9: partial byte then a whole command; partial byte inside a command
        spi_partial(3);
        run_cmd(8'd4, 24'h00007E, 1'b0, 8'h00);
        s0 = strobes;
        spi_byte(8'd5, rx);
        spi_partial(5);
        spi_byte(8'h34, rx);
        spi_byte(8'h12, rx);
        idle(4);
        check_eq("R9 command survives cs", strobes, s0 + 1);
        check_eq("R9 args after partial", {8'h0, mon_args}, 32'h1234);

        // R7: inter-byte gap expiry
        s0 = strobes;
        spi_byte(8'd5, rx);
        spi_byte(8'h33, rx);
        idle(400);
        spi_byte(8'd2, rx);
        idle(4);
        check_eq("R7 dropped command gives one strobe", strobes, s0 + 1);
        check_eq("R7 next byte is opcode", {24'h0, mon_op}, 32'h2);
        wait_drdy();
        spi_byte(8'h00, rx);
        check_eq("R7 new response byte0", {24'h0, rx}, {24'h0, rsp_model(8'd2, 24'h0) & 24'hFF});
        spi_byte(8'h00, rx);

        // R8: whole-exchange expiry with every gap below the gap limit
        s0 = strobes;
        spi_byte(8'd3, rx);
        idle(4);
        wait_drdy();
        spi_byte(8'h00, rx);
        check_eq("R8 byte0 before expiry", {24'h0, rx}, {24'h0, rsp_model(8'd3, 24'h0) & 24'hFF});
        idle(180);
        spi_byte(8'h00, rx);
        check_eq("R8 byte1 before expiry", {24'h0, rx}, {24'h0, 8'(rsp_model(8'd3, 24'h0) >> 8)});
        idle(250);
        check_eq("R8 drdy dropped", {31'h0, drdy}, 32'h0);
        spi_byte(8'h00, rx);
        check_eq("R8 remaining byte zero", {24'h0, rx}, 32'h0);
        check_eq("R8 no extra strobe", strobes, s0 + 1);

        // Random commands (R2 R4 R5)
        for (int n = 0; n < 24; n++) begin
            logic [7:0] op;
            op = 8'(1 + ($urandom % 7));
            run_cmd(op, 24'($urandom), 1'($urandom), 8'h00);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule